// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a down counter that can run in plain binary or as decimal decades, and it produces a waveform on its output pin. The waveform depends on the selected operating mode and on a gate input. An outer bus block writes a control word (mode code and decimal flag) and an initial count into the channel. The outer block also reads the live count, the output level and a flag that shows whether the last written count is still waiting to enter the counting element.

The block runs on one system clock. The count clock arrives as a one-cycle enable, `cnt_tick`, and each tick advances the counting element by one step. The gate input is sampled on every system clock, so a rising edge that falls between ticks is remembered until the next tick uses it. There are six modes: a terminal-count flag, a retriggerable one-shot, a rate generator, a square wave, a software-started strobe and a gate-started strobe. Mode codes 6 and 7 map onto the rate generator and the square wave. A written count of zero stands for the largest count the number system allows.

Top module: `pic_channel`

## Requirements
- R1: After reset, `out_level` is 0, `count_now` is 0 and `null_count` is 0.
- R2: A count write sets `null_count` to 1. The first load of that count into the counting element clears it. Writing a control word disarms the channel, and no load happens until a count is written after that control word.
- R3: Mode code 0. A control write or a count write drives `out_level` low. The first tick loads the count. Each later tick with `gate` high decrements it, and `out_level` goes high on the tick where the count reaches 0, which is N+1 ticks after the count write. While `gate` is low, the count holds.
- R4: Mode code 1. A `gate` rising edge triggers a load on the next tick and drives `out_level` low. The output rises on the Nth tick after the trigger tick. A new rising edge reloads the count and extends the pulse, and the pulse can be repeated without writing the count again.
- R5: Mode code 2. With `gate` high, the period is N ticks. `out_level` is low for exactly the one tick during which the count is 1, and then the count reloads from the written value. A count written while the channel runs takes effect at the next reload.
- R6: Mode code 3. The count steps by 2. For even N, `out_level` is high for N/2 ticks and low for N/2 ticks. For odd N, it is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R7: Mode code 4. `out_level` stays high until the count reaches 0 after a count write. It is then low for exactly one tick and returns high, once per written count.
- R8: Mode code 5. A `gate` rising edge loads the count on the next tick. The counter then decrements on every tick whatever the level of `gate`, and `out_level` is low for exactly one tick when the count reaches 0.
- R9: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R10: With the decimal flag set, each 4-bit digit counts 9 down to 0 with a borrow, so 0x0010 steps to 0x0009. A count of 0 steps to 0x9999 in decimal or to 0xFFFF in binary, which gives 10000 or 65536 steps.
- R11: In modes 2 and 3, a tick with `gate` low forces `out_level` high and holds the count. The next `gate` rising edge reloads the count on the following tick.
- R12: `count_now` shows the counting element. It changes only in a cycle where `cnt_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count clock enable, one cycle per count step |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_mode | input | 3 | Mode code 0 to 7 |
| ctrl_bcd | input | 1 | 1 selects decimal counting |
| count_wr | input | 1 | Initial count write strobe |
| count_val | input | WIDTH | Initial count value |
| gate | input | 1 | Gate level and trigger input |
| out_level | output | 1 | Channel output waveform |
| count_now | output | WIDTH | Live counting element value |
| null_count | output | 1 | Written count not yet loaded |

## Verification
The bench builds the channel with its default width of 16 bits, which is four decimal digits. At this width a written count of zero reaches both wrap points, 0xFFFF and 0x9999, in a single step. Decimal counts such as 0x0010 and 0x0013 force a borrow across a digit boundary in both the single-step and the double-step paths. Short counts of 2 to 6 keep every mode's full output period within a few ticks, so each output edge is checked on its exact tick. The long wrap periods are exercised only at their boundary values.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pic_mode_e;

  // Subtract 0..2 from one decimal digit; returns {borrow, digit}.
  function automatic logic [4:0] bcd_digit_sub(input logic [3:0] d, input logic [1:0] b);
    logic [3:0] diff;
    diff = d - {2'b00, b};
    if (d < {2'b00, b}) return {1'b1, diff + 4'd10};
    return {1'b0, diff};
  endfunction

  // Binary step of 1 or 2 with wrap.
  function automatic logic [16:0] bin_sub_step(input logic [15:0] v, input logic two);
    logic [16:0] r;
    r = {1'b0, v} - (two ? 17'd2 : 17'd1);
    return r;
  endfunction

endpackage

// File: rtl/pic_mode_decode.sv
module pic_mode_decode
  import pic_pkg::*;
(
  input  logic [2:0] code,
  output pic_mode_e  mode
);
  always_comb begin
    if (code[1]) mode = code[0] ? M_SQUARE : M_RATE;
    else         mode = pic_mode_e'(code);
  end
endmodule

// File: rtl/pic_gate_edge.sv
module pic_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic consume,
  output logic trig
);
  logic gate_q;
  logic pend_q;
  logic rise;

  assign rise = gate & ~gate_q;
  assign trig = pend_q | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (consume)   pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_decrement.sv
module pic_decrement
  import pic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] value,
  input  logic             bcd,
  input  logic             step2,
  output logic [WIDTH-1:0] result,
  output logic             wraps
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] bin_res;
  logic             bin_wrap;
  logic [WIDTH-1:0] bcd_res;
  logic [DIGITS:0]  brw;

  always_comb begin
    logic [WIDTH:0] t;
    t = {1'b0, value} - (step2 ? (WIDTH+1)'(2) : (WIDTH+1)'(1));
    bin_res  = t[WIDTH-1:0];
    bin_wrap = t[WIDTH];
  end

  assign brw[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [1:0] sub;
    logic [4:0] r;
    if (g == 0) begin : g_lsd
      assign sub = step2 ? 2'd2 : 2'd1;
    end else begin : g_upper
      assign sub = {1'b0, brw[g]};
    end
    assign r = bcd_digit_sub(value[4*g +: 4], sub);
    assign bcd_res[4*g +: 4] = r[3:0];
    assign brw[g+1] = r[4];
  end

  assign result = bcd ? bcd_res : bin_res;
  assign wraps  = bcd ? brw[DIGITS] : bin_wrap;
endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             ctrl_wr,
  input  logic [2:0]       ctrl_mode,
  input  logic             ctrl_bcd,
  input  logic             count_wr,
  input  logic [WIDTH-1:0] count_val,
  input  logic             gate,
  output logic             out_level,
  output logic [WIDTH-1:0] count_now,
  output logic             null_count
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] TWO  = WIDTH'(2);
  localparam logic [WIDTH-1:0] ZERO = '0;

  pic_mode_e        dec_mode;
  pic_mode_e        mode_q;
  logic             bcd_q;
  logic [WIDTH-1:0] init_q;
  logic [WIDTH-1:0] ce_q;
  logic             out_q;
  logic             null_q;
  logic             ctrl_ok;
  logic             count_ok;
  logic             running;
  logic             extra_q;
  logic             done_q;

  logic             armed;
  logic             tick_en;
  logic             trig;
  logic             step2;
  logic [WIDTH-1:0] dec_next;
  logic             ev_wrap;
  logic             ev_load;
  logic             next_zero;
  logic             next_one;
  logic             ce_is_one;
  logic             ce_is_two;
  logic [WIDTH-1:0] init_even;

  assign armed     = ctrl_ok & count_ok;
  assign tick_en   = cnt_tick & armed & ~ctrl_wr;
  assign step2     = (mode_q == M_SQUARE);
  assign next_zero = (dec_next == ZERO);
  assign next_one  = (dec_next == ONE);
  assign ce_is_one = (ce_q == ONE);
  assign ce_is_two = (ce_q == TWO);
  assign init_even = {init_q[WIDTH-1:1], 1'b0};

  pic_mode_decode u_mode (.code(ctrl_mode), .mode(dec_mode));

  pic_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .consume(tick_en), .trig(trig)
  );

  pic_decrement #(.WIDTH(WIDTH)) u_decr (
    .value(ce_q), .bcd(bcd_q), .step2(step2), .result(dec_next), .wraps(ev_wrap)
  );

  // Load event: initial count moves into the counting element on this tick.
  always_comb begin
    logic cond;
    case (mode_q)
      M_TERM, M_SWSTROBE:    cond = !running;
      M_ONESHOT, M_HWSTROBE: cond = trig;
      M_RATE:                cond = !running || trig || (gate && ce_is_one);
      M_SQUARE:              cond = !running || trig || (gate && !extra_q && ce_is_two);
      default:               cond = 1'b0;
    endcase
    ev_load = tick_en & cond;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      init_q   <= '0;
      ce_q     <= '0;
      out_q    <= 1'b0;
      null_q   <= 1'b0;
      ctrl_ok  <= 1'b0;
      count_ok <= 1'b0;
      running  <= 1'b0;
      extra_q  <= 1'b0;
      done_q   <= 1'b1;
    end else if (ctrl_wr) begin
      mode_q   <= dec_mode;
      bcd_q    <= ctrl_bcd;
      ctrl_ok  <= 1'b1;
      count_ok <= 1'b0;
      running  <= 1'b0;
      extra_q  <= 1'b0;
      done_q   <= 1'b1;
      out_q    <= (dec_mode != M_TERM);
    end else begin
      if (ev_load) null_q <= 1'b0;
      if (tick_en) begin
        case (mode_q)
          M_TERM: begin
            if (!running) begin
              ce_q    <= init_q;
              running <= 1'b1;
            end else if (gate) begin
              ce_q <= dec_next;
              if (next_zero) out_q <= 1'b1;
            end
          end
          M_SWSTROBE: begin
            if (!running) begin
              ce_q    <= init_q;
              running <= 1'b1;
              out_q   <= 1'b1;
              done_q  <= 1'b0;
            end else begin
              if (gate) ce_q <= dec_next;
              if (!out_q) out_q <= 1'b1;
              else if (gate && next_zero && !done_q) begin
                out_q  <= 1'b0;
                done_q <= 1'b1;
              end
            end
          end
          M_ONESHOT: begin
            if (trig) begin
              ce_q    <= init_q;
              out_q   <= 1'b0;
              running <= 1'b1;
            end else begin
              ce_q <= dec_next;
              if (next_zero) out_q <= 1'b1;
            end
          end
          M_HWSTROBE: begin
            if (trig) begin
              ce_q    <= init_q;
              out_q   <= 1'b1;
              done_q  <= 1'b0;
              running <= 1'b1;
            end else begin
              ce_q <= dec_next;
              if (!out_q) out_q <= 1'b1;
              else if (next_zero && !done_q) begin
                out_q  <= 1'b0;
                done_q <= 1'b1;
              end
            end
          end
          M_RATE: begin
            if (!running || trig) begin
              ce_q    <= init_q;
              out_q   <= 1'b1;
              running <= 1'b1;
            end else if (!gate) begin
              out_q <= 1'b1;
            end else if (ce_is_one) begin
              ce_q  <= init_q;
              out_q <= 1'b1;
            end else begin
              ce_q <= dec_next;
              if (next_one) out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (!running || trig) begin
              ce_q    <= init_even;
              extra_q <= init_q[0];
              out_q   <= 1'b1;
              running <= 1'b1;
            end else if (!gate) begin
              out_q <= 1'b1;
            end else if (extra_q) begin
              extra_q <= 1'b0;
            end else if (ce_is_two) begin
              out_q   <= ~out_q;
              ce_q    <= init_even;
              extra_q <= init_q[0] & ~out_q;
            end else begin
              ce_q <= dec_next;
            end
          end
          default: ;
        endcase
      end
      // A count write overrides the tick results of the same cycle.
      if (count_wr) begin
        init_q   <= count_val;
        count_ok <= 1'b1;
        null_q   <= 1'b1;
        if (mode_q == M_TERM || mode_q == M_SWSTROBE) running <= 1'b0;
        if (mode_q == M_TERM) out_q <= 1'b0;
      end
    end
  end

  assign out_level  = out_q;
  assign count_now  = ce_q;
  assign null_count = null_q;
endmodule

// File: rtl/pic_channel_chk.sv
module pic_channel_chk
  import pic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             ctrl_wr,
  input logic             count_wr,
  input logic             gate,
  input logic             out_level,
  input logic [WIDTH-1:0] count_now,
  input logic             null_count,
  input pic_mode_e        mode_q,
  input logic             ev_load,
  input logic             ev_wrap
);
  AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr && !ctrl_wr |=> null_count); // R2

  AST_LOAD_CLEARS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load && !count_wr |=> !null_count); // R2

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(count_now)); // R12

  AST_TERM_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM) && count_wr && !ctrl_wr |=> !out_level); // R3

  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_level && cnt_tick && !ctrl_wr
    |=> out_level); // R7

  AST_GATE_LOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE || mode_q == M_SQUARE) && cnt_tick && !gate && !ctrl_wr
    |=> out_level); // R11

  AST_WRAP_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |-> (count_now <= WIDTH'(1))); // R10
endmodule

bind pic_channel pic_channel_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ctrl_wr(ctrl_wr),
  .count_wr(count_wr), .gate(gate), .out_level(out_level),
  .count_now(count_now), .null_count(null_count), .mode_q(mode_q),
  .ev_load(ev_load), .ev_wrap(ev_wrap)
);

// File: tb/test_pic_channel.sv
module test_pic_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick = 1'b0;
  logic         ctrl_wr = 1'b0;
  logic [2:0]   ctrl_mode = 3'd0;
  logic         ctrl_bcd = 1'b0;
  logic         count_wr = 1'b0;
  logic [W-1:0] count_val = '0;
  logic         gate = 1'b0;
  logic         out_level;
  logic [W-1:0] count_now;
  logic         null_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 1'b0;

  always #10 clk = ~clk;

  pic_channel #(.WIDTH(W)) i_pic_channel (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ctrl_wr(ctrl_wr),
    .ctrl_mode(ctrl_mode), .ctrl_bcd(ctrl_bcd), .count_wr(count_wr),
    .count_val(count_val), .gate(gate), .out_level(out_level),
    .count_now(count_now), .null_count(null_count)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] cnt;
    logic        gt;
    logic [7:0]  k;
    logic        eo;
    logic [15:0] ec;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'd5,      1'b1, 8'd5, 1'b0, 16'd1,      8'd3},  // R3
    '{3'd0, 1'b0, 16'd5,      1'b1, 8'd6, 1'b1, 16'd0,      8'd3},  // R3
    '{3'd0, 1'b0, 16'd5,      1'b1, 8'd8, 1'b1, 16'hFFFE,   8'd3},  // R3
    '{3'd0, 1'b0, 16'd5,      1'b0, 8'd4, 1'b0, 16'd5,      8'd3},  // R3 gate hold
    '{3'd1, 1'b0, 16'd3,      1'b1, 8'd3, 1'b0, 16'd1,      8'd4},  // R4
    '{3'd1, 1'b0, 16'd3,      1'b1, 8'd4, 1'b1, 16'd0,      8'd4},  // R4
    '{3'd2, 1'b0, 16'd4,      1'b1, 8'd4, 1'b0, 16'd1,      8'd5},  // R5
    '{3'd2, 1'b0, 16'd4,      1'b1, 8'd5, 1'b1, 16'd4,      8'd5},  // R5
    '{3'd2, 1'b0, 16'd4,      1'b1, 8'd8, 1'b0, 16'd1,      8'd5},  // R5
    '{3'd6, 1'b0, 16'd4,      1'b1, 8'd4, 1'b0, 16'd1,      8'd9},  // R9
    '{3'd3, 1'b0, 16'd4,      1'b1, 8'd2, 1'b1, 16'd2,      8'd6},  // R6
    '{3'd3, 1'b0, 16'd4,      1'b1, 8'd3, 1'b0, 16'd4,      8'd6},  // R6
    '{3'd3, 1'b0, 16'd4,      1'b1, 8'd5, 1'b1, 16'd4,      8'd6},  // R6
    '{3'd3, 1'b0, 16'd5,      1'b1, 8'd3, 1'b1, 16'd2,      8'd6},  // R6
    '{3'd3, 1'b0, 16'd5,      1'b1, 8'd4, 1'b0, 16'd4,      8'd6},  // R6
    '{3'd3, 1'b0, 16'd5,      1'b1, 8'd6, 1'b1, 16'd4,      8'd6},  // R6
    '{3'd7, 1'b0, 16'd5,      1'b1, 8'd4, 1'b0, 16'd4,      8'd9},  // R9
    '{3'd4, 1'b0, 16'd3,      1'b1, 8'd4, 1'b0, 16'd0,      8'd7},  // R7
    '{3'd4, 1'b0, 16'd3,      1'b1, 8'd5, 1'b1, 16'hFFFF,   8'd7},  // R7
    '{3'd5, 1'b0, 16'd2,      1'b1, 8'd3, 1'b0, 16'd0,      8'd8},  // R8
    '{3'd5, 1'b0, 16'd2,      1'b1, 8'd4, 1'b1, 16'hFFFF,   8'd8},  // R8
    '{3'd0, 1'b1, 16'h0010,   1'b1, 8'd2, 1'b0, 16'h0009,   8'd10}, // R10
    '{3'd0, 1'b1, 16'h0000,   1'b1, 8'd2, 1'b0, 16'h9999,   8'd10}, // R10
    '{3'd0, 1'b0, 16'h0000,   1'b1, 8'd2, 1'b0, 16'hFFFF,   8'd10}, // R10
    '{3'd3, 1'b1, 16'h0013,   1'b1, 8'd4, 1'b1, 16'h0008,   8'd10}  // R10 with R6
  };

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_ctrl(input logic [2:0] m, input logic b);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_mode = m; ctrl_bcd = b;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic do_count(input logic [W-1:0] v);
    @(negedge clk);
    count_wr = 1'b1; count_val = v;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk);
    gate = v;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_tick = 1'b1;
      @(negedge clk);
      cnt_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  vec_t v;

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 out", {31'd0, out_level}, 32'd0);
    chk("R1 count", {16'd0, count_now}, 32'd0);
    chk("R1 null", {31'd0, null_count}, 32'd0);

    // Vector table walk (count checks also cover R12)
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      set_gate(1'b0);
      do_ctrl(v.mode, v.bcd);
      do_count(v.cnt);
      set_gate(v.gt);
      ticks(int'(v.k));
      chk($sformatf("R%0d vec%0d out", v.req, i), {31'd0, out_level}, {31'd0, v.eo});
      chk($sformatf("R%0d R12 vec%0d count", v.req, i), {16'd0, count_now}, {16'd0, v.ec});
    end

    // R2: count written before the control word does not arm the channel
    do_reset();
    do_count(16'd7);
    chk("R2 null after write", {31'd0, null_count}, 32'd1);
    do_ctrl(3'd0, 1'b0);
    set_gate(1'b1);
    ticks(3);
    chk("R2 unarmed count", {16'd0, count_now}, 32'd0);
    chk("R2 unarmed null", {31'd0, null_count}, 32'd1);
    do_count(16'd7);
    ticks(1);
    chk("R2 loaded count", {16'd0, count_now}, 32'd7);
    chk("R2 null cleared", {31'd0, null_count}, 32'd0);

    // R4: retrigger extends the pulse, repeat without rewrite
    set_gate(1'b0);
    do_ctrl(3'd1, 1'b0);
    do_count(16'd3);
    set_gate(1'b1);
    ticks(2);
    chk("R4 before retrigger", {16'd0, count_now}, 32'd2);
    set_gate(1'b0);
    set_gate(1'b1);
    ticks(1);
    chk("R4 retrigger count", {16'd0, count_now}, 32'd3);
    chk("R4 retrigger out", {31'd0, out_level}, 32'd0);
    ticks(2);
    chk("R4 still low", {31'd0, out_level}, 32'd0);
    ticks(1);
    chk("R4 pulse end", {31'd0, out_level}, 32'd1);
    set_gate(1'b0);
    set_gate(1'b1);
    ticks(1);
    chk("R4 repeat count", {16'd0, count_now}, 32'd3);
    chk("R4 repeat out", {31'd0, out_level}, 32'd0);

    // R11: gate low in rate mode forces high, rising edge reloads
    set_gate(1'b0);
    do_ctrl(3'd2, 1'b0);
    do_count(16'd4);
    set_gate(1'b1);
    ticks(4);
    chk("R11 pre low out", {31'd0, out_level}, 32'd0);
    set_gate(1'b0);
    ticks(1);
    chk("R11 forced high", {31'd0, out_level}, 32'd1);
    chk("R11 count held", {16'd0, count_now}, 32'd1);
    set_gate(1'b1);
    ticks(1);
    chk("R11 reload", {16'd0, count_now}, 32'd4);
    ticks(1);
    chk("R11 resumed", {16'd0, count_now}, 32'd3);

    // R5 with R2: new count while running takes effect at reload
    set_gate(1'b0);
    do_ctrl(3'd2, 1'b0);
    do_count(16'd4);
    set_gate(1'b1);
    ticks(2);
    chk("R5 mid count", {16'd0, count_now}, 32'd3);
    do_count(16'd6);
    chk("R2 null mid run", {31'd0, null_count}, 32'd1);
    ticks(2);
    chk("R5 low at one", {31'd0, out_level}, 32'd0);
    chk("R2 null until reload", {31'd0, null_count}, 32'd1);
    ticks(1);
    chk("R5 new count loaded", {16'd0, count_now}, 32'd6);
    chk("R2 null after reload", {31'd0, null_count}, 32'd0);

    summary();
  end
endmodule